// File: doc/BRIEF.md
# Sectored Page Cache Fill Controller

This block holds the tag state of a set-associative DRAM cache whose lines are whole pages. Each page is cut into sub-blocks, and every sub-block has its own valid bit and dirty bit. One tag and one owner id are kept per page. The block also keeps one access stamp per page, taken from a free-running cycle counter.

An insert request carries a block address and an owner id, and it is accepted on a valid/ready handshake. The controller then looks up the set and decides among three cases: reject the request, fill one missing sub-block of a page that is already resident, or evict a way and install the new page. The result is a sequence of commands on a valid/ready output. Each command carries a kind, an address and an owner id.

A separate write-hit strobe marks a resident sub-block dirty. Dirty sub-blocks are written back later, when their way is evicted.

Top module: `pcf_fill_ctrl`

## Requirements
- R1: After reset, `ins_ready` is 1, `cmd_valid` is 0, and every way of every set is invalid.
- R2: An insert whose sub-block is already valid under a matching page tag emits no command. The cache state is left unchanged.
- R3: An insert that matches a valid page whose requested sub-block is invalid emits exactly one fill write for that sub-block. It evicts nothing. The sub-block becomes valid and clean, and the way's stamp is refreshed.
- R4: The fields of the block address are mapped as follows:
  - sub-block index = `blk[SUB_BITS-1:0]`;
  - page = `blk >> SUB_BITS`, which is the stored tag;
  - set = page mod SETS.
  
  A local address is `(way*SETS + set) * 2^PAGE_BITS + sub * 2^BLK_BITS`, where `PAGE_BITS = BLK_BITS + SUB_BITS`.
- R5: On a miss, the victim is the lowest-numbered way with no valid sub-block. If every way holds a page, the victim is the way with the smallest stamp, and a tie goes to the lower way.
- R6: Evicting a valid way emits two commands for each dirty sub-block, in ascending sub-block order. The first is a migrate read of the local address. The second is a writeback write to `old_tag * 2^PAGE_BITS + sub * 2^BLK_BITS`. Both carry the evicted page's owner id.
- R7: After any walk, a fill write of the requested sub-block follows, carrying the requester's owner id. The new page holds only that sub-block, valid and clean, together with the new tag, owner and stamp.
- R8: A write-hit sets the dirty bit of the addressed sub-block only if that sub-block is valid under a matching tag. Otherwise the write-hit is ignored.
- R9: `ins_ready` is 0 from acceptance until the last command of that insert has been handshaken. A command is held unchanged while `cmd_ready` is low.
- R10: `cmd_kind` encodes the command type as 0 = fill write, 1 = migrate read, 2 = writeback write. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request present |
| ins_ready | output | 1 | Controller idle and able to take an insert |
| ins_blk | input | ADDR_W | Block address of the insert |
| ins_owner | input | OWN_W | Owner id of the insert |
| wr_hit_valid | input | 1 | Write-hit strobe |
| wr_hit_blk | input | ADDR_W | Block address written |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command taken |
| cmd_kind | output | 2 | 0 fill write, 1 migrate read, 2 writeback write |
| cmd_addr | output | ADDR_W+BLK_BITS | Local or backing address |
| cmd_owner | output | OWN_W | Owner id attached to the command |

## Verification
The assertions check the following properties on every cycle:
- the command handshake keeps its payload steady under backpressure;
- `ins_ready` stays low while a command is pending;
- every migrate read is followed immediately by a writeback write;
- a fill write is the final command of an insert;
- a rejected insert emits nothing;
- at most one way of a set matches a page.

Other properties can only be shown by the bench's sweeps against its own model of the tag store. These are the choice of victim by stamp, the ascending order of the walk and its address arithmetic, the clean state of freshly filled sub-blocks, and write-hits being ignored when they miss.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

  typedef enum logic [1:0] {
    CMD_FILL   = 2'd0,
    CMD_MIG_RD = 2'd1,
    CMD_WB_WR  = 2'd2
  } pcf_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MIG_RD,
    ST_WB_WR,
    ST_FILL
  } pcf_state_e;

  // Address of a sub-block inside the cache: line slot scaled by page size.
  function automatic logic [31:0] local_addr(input logic [31:0] line,
                                             input logic [31:0] sub,
                                             input int unsigned page_bits,
                                             input int unsigned blk_bits);
    return (line << page_bits) + (sub << blk_bits);
  endfunction

  // Address of a sub-block in backing memory, rebuilt from the page tag.
  function automatic logic [31:0] backing_addr(input logic [31:0] tag,
                                               input logic [31:0] sub,
                                               input int unsigned page_bits,
                                               input int unsigned blk_bits);
    return (tag << page_bits) + (sub << blk_bits);
  endfunction

endpackage

// File: rtl/pcf_set_match.sv
module pcf_set_match #(
  parameter int WAYS     = 2,
  parameter int SUBS     = 4,
  parameter int TAG_W    = 10,
  parameter int WAY_BITS = 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0][SUBS-1:0]  way_vld,
  input  logic [TAG_W-1:0]           page,
  input  logic [SUBS-1:0]            sub_bit,
  output logic [WAYS-1:0]            page_match,
  output logic                       full_hit,
  output logic [WAY_BITS-1:0]        hit_way
);
  logic [WAYS-1:0] sub_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign page_match[w] = (|way_vld[w]) && (way_tag[w] == page);
    assign sub_hit[w]    = page_match[w] && (|(way_vld[w] & sub_bit));
  end

  assign full_hit = |sub_hit;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (page_match[w]) hit_way = WAY_BITS'(w);
    end
  end
endmodule

// File: rtl/pcf_victim_pick.sv
module pcf_victim_pick #(
  parameter int WAYS     = 2,
  parameter int SUBS     = 4,
  parameter int TS_W     = 16,
  parameter int WAY_BITS = 1
) (
  input  logic [WAYS-1:0][SUBS-1:0] way_vld,
  input  logic [WAYS-1:0][TS_W-1:0] way_ts,
  output logic [WAY_BITS-1:0]       vict_way,
  output logic                      vict_valid
);
  logic                found;
  logic [WAY_BITS-1:0] free_way;
  logic [WAY_BITS-1:0] old_way;

  always_comb begin
    found    = 1'b0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && (way_vld[w] == '0)) begin
        found    = 1'b1;
        free_way = WAY_BITS'(w);
      end
    end
    old_way = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (way_ts[w] < way_ts[old_way]) old_way = WAY_BITS'(w);
    end
  end

  assign vict_way   = found ? free_way : old_way;
  assign vict_valid = !found;
endmodule

// File: rtl/pcf_dirty_walk.sv
module pcf_dirty_walk #(
  parameter int SUBS     = 4,
  parameter int SUB_BITS = 2
) (
  input  logic [SUBS-1:0]     mask,
  output logic [SUB_BITS-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = SUBS - 1; i >= 0; i--) begin
      if (mask[i]) idx = SUB_BITS'(i);
    end
  end
endmodule

// File: rtl/pcf_fill_ctrl.sv
module pcf_fill_ctrl
  import pcf_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int SETS     = 4,
  parameter int WAYS     = 2,
  parameter int SUBS     = 4,
  parameter int BLK_BITS = 6,
  parameter int TS_W     = 16,
  parameter int OWN_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ins_valid,
  output logic                       ins_ready,
  input  logic [ADDR_W-1:0]          ins_blk,
  input  logic [OWN_W-1:0]           ins_owner,
  input  logic                       wr_hit_valid,
  input  logic [ADDR_W-1:0]          wr_hit_blk,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic [1:0]                 cmd_kind,
  output logic [ADDR_W+BLK_BITS-1:0] cmd_addr,
  output logic [OWN_W-1:0]           cmd_owner
);
  localparam int SUB_BITS  = $clog2(SUBS);
  localparam int SET_BITS  = $clog2(SETS);
  localparam int WAY_BITS  = $clog2(WAYS);
  localparam int LINE_BITS = WAY_BITS + SET_BITS;
  localparam int LINES     = 1 << LINE_BITS;
  localparam int PAGE_BITS = BLK_BITS + SUB_BITS;
  localparam int TAG_W     = ADDR_W - SUB_BITS;
  localparam int CMD_AW    = ADDR_W + BLK_BITS;

  // Tag store, one entry per (way, set) slot.
  logic [TAG_W-1:0] tag_q [LINES];
  logic [SUBS-1:0]  vld_q [LINES];
  logic [SUBS-1:0]  drt_q [LINES];
  logic [TS_W-1:0]  ts_q  [LINES];
  logic [OWN_W-1:0] own_q [LINES];

  pcf_state_e          state_q;
  logic [TS_W-1:0]     stamp_q;
  logic [ADDR_W-1:0]   req_blk_q;
  logic [OWN_W-1:0]    req_own_q;
  logic [WAY_BITS-1:0] way_q;
  logic [TAG_W-1:0]    old_tag_q;
  logic [OWN_W-1:0]    old_own_q;
  logic [SUBS-1:0]     walk_q;

  // Fields of the pending request and of the write-hit.
  logic [SUB_BITS-1:0] req_sub, wh_sub;
  logic [TAG_W-1:0]    req_page, wh_page;
  logic [SET_BITS-1:0] req_set, wh_set;
  logic [SUBS-1:0]     req_bit, wh_bit;

  assign req_sub  = req_blk_q[SUB_BITS-1:0];
  assign req_page = req_blk_q[ADDR_W-1:SUB_BITS];
  assign req_set  = req_page[SET_BITS-1:0];
  assign req_bit  = SUBS'(1) << req_sub;
  assign wh_sub   = wr_hit_blk[SUB_BITS-1:0];
  assign wh_page  = wr_hit_blk[ADDR_W-1:SUB_BITS];
  assign wh_set   = wh_page[SET_BITS-1:0];
  assign wh_bit   = SUBS'(1) << wh_sub;

  // Per-way views of the addressed sets.
  logic [WAYS-1:0][TAG_W-1:0] rs_tag, ws_tag;
  logic [WAYS-1:0][SUBS-1:0]  rs_vld, ws_vld;
  logic [WAYS-1:0][TS_W-1:0]  rs_ts;

  for (genvar w = 0; w < WAYS; w++) begin : g_view
    localparam logic [WAY_BITS-1:0] WV = WAY_BITS'(w);
    assign rs_tag[w] = tag_q[{WV, req_set}];
    assign rs_vld[w] = vld_q[{WV, req_set}];
    assign rs_ts[w]  = ts_q[{WV, req_set}];
    assign ws_tag[w] = tag_q[{WV, wh_set}];
    assign ws_vld[w] = vld_q[{WV, wh_set}];
  end

  // Named internal events, also observed by the checker.
  logic [WAYS-1:0]     look_match, wh_match;
  logic                look_full, wh_full;
  logic [WAY_BITS-1:0] hit_way, wh_way, vict_way;
  logic                vict_valid;
  logic                in_look, ev_reject, ev_partial, wh_apply;
  logic [LINE_BITS-1:0] hit_line, vict_line, wh_line;
  logic [SUB_BITS-1:0] walk_idx;
  logic [SUBS-1:0]     walk_left;

  pcf_set_match #(.WAYS(WAYS), .SUBS(SUBS), .TAG_W(TAG_W), .WAY_BITS(WAY_BITS)) u_req_match (
    .way_tag(rs_tag), .way_vld(rs_vld), .page(req_page), .sub_bit(req_bit),
    .page_match(look_match), .full_hit(look_full), .hit_way(hit_way)
  );

  pcf_set_match #(.WAYS(WAYS), .SUBS(SUBS), .TAG_W(TAG_W), .WAY_BITS(WAY_BITS)) u_wh_match (
    .way_tag(ws_tag), .way_vld(ws_vld), .page(wh_page), .sub_bit(wh_bit),
    .page_match(wh_match), .full_hit(wh_full), .hit_way(wh_way)
  );

  pcf_victim_pick #(.WAYS(WAYS), .SUBS(SUBS), .TS_W(TS_W), .WAY_BITS(WAY_BITS)) u_victim (
    .way_vld(rs_vld), .way_ts(rs_ts), .vict_way(vict_way), .vict_valid(vict_valid)
  );

  pcf_dirty_walk #(.SUBS(SUBS), .SUB_BITS(SUB_BITS)) u_walk (
    .mask(walk_q), .idx(walk_idx)
  );

  assign in_look    = (state_q == ST_LOOK);
  assign ev_reject  = in_look && look_full;
  assign ev_partial = in_look && !look_full && (|look_match);
  assign wh_apply   = wr_hit_valid && wh_full;
  assign hit_line   = {hit_way, req_set};
  assign vict_line  = {vict_way, req_set};
  assign wh_line    = {wh_way, wh_set};
  assign walk_left  = walk_q & ~(SUBS'(1) << walk_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      stamp_q   <= '0;
      req_blk_q <= '0;
      req_own_q <= '0;
      way_q     <= '0;
      old_tag_q <= '0;
      old_own_q <= '0;
      walk_q    <= '0;
      for (int l = 0; l < LINES; l++) begin
        tag_q[l] <= '0;
        vld_q[l] <= '0;
        drt_q[l] <= '0;
        ts_q[l]  <= '0;
        own_q[l] <= '0;
      end
    end else begin
      stamp_q <= stamp_q + 1'b1;
      if (wh_apply) drt_q[wh_line] <= drt_q[wh_line] | wh_bit;
      case (state_q)
        ST_IDLE: begin
          if (ins_valid) begin
            req_blk_q <= ins_blk;
            req_own_q <= ins_owner;
            state_q   <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (look_full) begin
            state_q <= ST_IDLE;
          end else if (|look_match) begin
            way_q           <= hit_way;
            vld_q[hit_line] <= vld_q[hit_line] | req_bit;
            drt_q[hit_line] <= (drt_q[hit_line] |
                                ((wh_apply && (wh_line == hit_line)) ? wh_bit : '0)) & ~req_bit;
            ts_q[hit_line]  <= stamp_q;
            state_q         <= ST_FILL;
          end else begin
            way_q            <= vict_way;
            old_tag_q        <= tag_q[vict_line];
            old_own_q        <= own_q[vict_line];
            walk_q           <= vict_valid ? drt_q[vict_line] : '0;
            tag_q[vict_line] <= req_page;
            own_q[vict_line] <= req_own_q;
            ts_q[vict_line]  <= stamp_q;
            vld_q[vict_line] <= req_bit;
            drt_q[vict_line] <= '0;
            state_q <= (vict_valid && (|drt_q[vict_line])) ? ST_MIG_RD : ST_FILL;
          end
        end
        ST_MIG_RD: if (cmd_ready) state_q <= ST_WB_WR;
        ST_WB_WR: begin
          if (cmd_ready) begin
            walk_q  <= walk_left;
            state_q <= (|walk_left) ? ST_MIG_RD : ST_FILL;
          end
        end
        ST_FILL: if (cmd_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pcf_cmd_e    kind_e;
  logic [31:0] addr32;

  always_comb begin
    case (state_q)
      ST_MIG_RD: begin
        kind_e    = CMD_MIG_RD;
        addr32    = local_addr(32'({way_q, req_set}), 32'(walk_idx), PAGE_BITS, BLK_BITS);
        cmd_owner = old_own_q;
      end
      ST_WB_WR: begin
        kind_e    = CMD_WB_WR;
        addr32    = backing_addr(32'(old_tag_q), 32'(walk_idx), PAGE_BITS, BLK_BITS);
        cmd_owner = old_own_q;
      end
      default: begin
        kind_e    = CMD_FILL;
        addr32    = local_addr(32'({way_q, req_set}), 32'(req_sub), PAGE_BITS, BLK_BITS);
        cmd_owner = req_own_q;
      end
    endcase
  end

  assign cmd_kind  = kind_e;
  assign cmd_addr  = addr32[CMD_AW-1:0];
  assign cmd_valid = (state_q == ST_MIG_RD) || (state_q == ST_WB_WR) || (state_q == ST_FILL);
  assign ins_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/pcf_fill_chk.sv
module pcf_fill_chk #(
  parameter int WAYS   = 2,
  parameter int CMD_AW = 18,
  parameter int OWN_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_kind,
  input logic [CMD_AW-1:0] cmd_addr,
  input logic [OWN_W-1:0]  cmd_owner,
  input logic              ev_reject,
  input logic              ev_partial,
  input logic              in_look,
  input logic [WAYS-1:0]   look_match,
  input logic [WAYS-1:0]   wh_match,
  input logic              wr_hit_valid
);
  // R9
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !ins_ready);

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) &&
                                   $stable(cmd_addr) && $stable(cmd_owner)));

  // R10
  kind_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_kind != 2'd3));

  // R6
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == 2'd1) |=> (cmd_valid && cmd_kind == 2'd2));

  // R7
  fill_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == 2'd0) |=> (!cmd_valid && ins_ready));

  // R2
  reject_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (!cmd_valid && ins_ready));

  // R3
  partial_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_partial |=> (cmd_valid && cmd_kind == 2'd0));

  // R5
  unique_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_look |-> $onehot0(look_match));

  // R8
  unique_wh_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_valid |-> $onehot0(wh_match));
endmodule

bind pcf_fill_ctrl pcf_fill_chk #(.WAYS(WAYS), .CMD_AW(ADDR_W + BLK_BITS), .OWN_W(OWN_W)) u_fill_chk (
  .clk(clk), .rst_n(rst_n), .ins_ready(ins_ready), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_owner(cmd_owner),
  .ev_reject(ev_reject), .ev_partial(ev_partial), .in_look(in_look),
  .look_match(look_match), .wh_match(wh_match), .wr_hit_valid(wr_hit_valid)
);

// File: tb/pcf_fill_ctrl_bench.sv
module pcf_fill_ctrl_bench;
  localparam int ADDR_W = 12, SETS = 4, WAYS = 2, SUBS = 4, BLK_BITS = 6, TS_W = 16, OWN_W = 4;
  localparam int SUB_BITS = 2, PAGE_BITS = BLK_BITS + SUB_BITS, CMD_AW = ADDR_W + BLK_BITS;
  localparam int LINES = SETS * WAYS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, ins_ready;
  logic [ADDR_W-1:0] ins_blk = '0;
  logic [OWN_W-1:0] ins_owner = '0;
  logic wr_hit_valid = 1'b0;
  logic [ADDR_W-1:0] wr_hit_blk = '0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_kind;
  logic [CMD_AW-1:0] cmd_addr;
  logic [OWN_W-1:0] cmd_owner;

  always #10 clk = ~clk;

  pcf_fill_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .SUBS(SUBS),
                  .BLK_BITS(BLK_BITS), .TS_W(TS_W), .OWN_W(OWN_W)) u_pcf_fill_ctrl (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_blk(ins_blk), .ins_owner(ins_owner), .wr_hit_valid(wr_hit_valid),
    .wr_hit_blk(wr_hit_blk), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_owner(cmd_owner)
  );

  int nchecks = 0, nerr = 0;
  logic [15:0] rng = 16'hACE1;

  // Bench model of the tag store.
  int m_tag [LINES];
  logic [SUBS-1:0] m_vld [LINES];
  logic [SUBS-1:0] m_drt [LINES];
  int m_ts [LINES];
  int m_own [LINES];
  int stamp = 0;

  int ek [64], ea [64], eo [64];
  string et [64];
  int ne;
  int gk [64], ga [64], go [64];
  int ng;

  task automatic step_rng();
    rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int slot_addr(input int w, input int s, input int i);
    return (w * SETS + s) * (1 << PAGE_BITS) + i * (1 << BLK_BITS);
  endfunction

  task automatic push(input int k, input int a, input int o, input string t);
    ek[ne] = k; ea[ne] = a; eo[ne] = o; et[ne] = t; ne++;
  endtask

  task automatic model_insert(input int blk, input int own);
    int sub, page, s, hit, v, lv;
    sub = blk % SUBS; page = blk / SUBS; s = page % SETS;
    ne = 0; hit = -1;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[w*SETS+s] != 0 && m_tag[w*SETS+s] == page) hit = w;
    stamp++;
    if (hit >= 0) begin
      lv = hit * SETS + s;
      if (m_vld[lv][sub]) return;
      push(0, slot_addr(hit, s, sub), own, "R3");
      m_vld[lv][sub] = 1'b1; m_drt[lv][sub] = 1'b0; m_ts[lv] = stamp;
      return;
    end
    v = -1;
    for (int w = 0; w < WAYS; w++)
      if (v < 0 && m_vld[w*SETS+s] == 0) v = w;
    if (v < 0) begin
      v = 0;
      for (int w = 1; w < WAYS; w++)
        if (m_ts[w*SETS+s] < m_ts[v*SETS+s]) v = w;
    end
    lv = v * SETS + s;
    if (m_vld[lv] != 0) begin
      for (int i = 0; i < SUBS; i++) begin
        if (m_drt[lv][i]) begin
          push(1, slot_addr(v, s, i), m_own[lv], "R6");
          push(2, m_tag[lv] * (1 << PAGE_BITS) + i * (1 << BLK_BITS), m_own[lv], "R6 R8");
        end
      end
      push(0, slot_addr(v, s, sub), own, "R5 R7");
    end else begin
      push(0, slot_addr(v, s, sub), own, "R4");
    end
    m_tag[lv] = page; m_own[lv] = own; m_ts[lv] = stamp;
    m_vld[lv] = '0; m_vld[lv][sub] = 1'b1; m_drt[lv] = '0;
  endtask

  task automatic model_whit(input int blk);
    int sub, page, s;
    sub = blk % SUBS; page = blk / SUBS; s = page % SETS;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[w*SETS+s][sub] && m_tag[w*SETS+s] == page) m_drt[w*SETS+s][sub] = 1'b1;
  endtask

  task automatic do_whit(input int blk);
    model_whit(blk);
    @(negedge clk);
    wr_hit_valid = 1'b1; wr_hit_blk = ADDR_W'(blk);
    @(negedge clk);
    wr_hit_valid = 1'b0;
  endtask

  task automatic do_insert(input int blk, input int own);
    bit done;
    int busy_bad;
    model_insert(blk, own);
    @(negedge clk);
    ins_valid = 1'b1; ins_blk = ADDR_W'(blk); ins_owner = OWN_W'(own);
    @(negedge clk);
    ins_valid = 1'b0;
    ng = 0; done = 1'b0; busy_bad = 0;
    for (int c = 0; c < 400 && !done; c++) begin
      if (ins_ready && !cmd_valid) done = 1'b1;
      else begin
        if (cmd_valid && ins_ready) busy_bad++;
        step_rng();
        cmd_ready = (rng[1:0] != 2'd0);
        if (cmd_valid && cmd_ready && ng < 64) begin
          gk[ng] = int'(cmd_kind); ga[ng] = int'(cmd_addr); go[ng] = int'(cmd_owner);
          ng++;
        end
        @(negedge clk);
      end
    end
    chk(done, "R9", "insert completes", int'(done), 1);
    chk(busy_bad == 0, "R9", "ready low while busy", busy_bad, 0);
    chk(ng == ne, (ne == 0) ? "R2" : et[ne-1], "command count", ng, ne);
    for (int i = 0; i < ne && i < ng; i++) begin
      chk(gk[i] == ek[i], "R10", "command kind", gk[i], ek[i]);
      chk(ga[i] == ea[i], et[i], "command address", ga[i], ea[i]);
      chk(go[i] == eo[i], et[i], "command owner", go[i], eo[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchecks++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    for (int l = 0; l < LINES; l++) begin
      m_tag[l] = 0; m_vld[l] = '0; m_drt[l] = '0; m_ts[l] = 0; m_own[l] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ins_ready == 1'b1, "R1", "ins_ready after reset", int'(ins_ready), 1);
    chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);

    // R4 cold fills of two pages per set
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++)
        do_insert((s + SETS * k) * SUBS + (s + k) % SUBS, s + k);
    // R2 repeats are rejected
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++)
        do_insert((s + SETS * k) * SUBS + (s + k) % SUBS, 9);
    // R3 partial fills of a neighbouring sub-block
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++)
        do_insert((s + SETS * k) * SUBS + (s + k + 1) % SUBS, 5);
    // R8 write-hits to valid and to invalid sub-blocks
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++) begin
        do_whit((s + SETS * k) * SUBS + (s + k) % SUBS);
        do_whit((s + SETS * k) * SUBS + (s + k + 2) % SUBS);
      end
    // R5 R6 R7 evictions of the least recently stamped way
    for (int s = 0; s < SETS; s++)
      do_insert((s + SETS * 2) * SUBS, 7);
    // Mixed sweep over a small page pool
    for (int n = 0; n < 400; n++) begin
      step_rng();
      if (rng[2]) do_whit(int'(rng[9:4]));
      step_rng();
      do_insert(int'(rng[11:6]), int'(rng[3:0]));
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule